// File: doc/BRIEF.md
# Non-pipelined integer multiply issue scheduler

This block sits beside the integer issue logic and decides when a multiply may start on a multiplier that cannot be pipelined. The multiplier is fed through integer pipe E0. A requester raises a request with a size code and a dependency description, and holds it steady until the block answers with a one-cycle grant. From that grant the block keeps track of four things: how long the multiplier stays occupied, which later E0 cycle is claimed for the multiply's writeback, when the result becomes available, and whether a dependent multiply has waited long enough. It then drives a busy flag, an E0 block flag and a one-cycle result-valid pulse. The arithmetic is not part of this block. In its place the result pulse carries the size code of the multiply that completed.

Every multiply reads its operands from the register file and never from the forwarding network. The requester gives the distance, in cycles, from the issue of the operand's producer to the cycle right after the request is first presented. For every cycle the request waits, the block adds one to that distance and then derives the latency penalty from the result. A separate flag marks an operand that comes from the most recently granted multiply. In that case the new multiply is held back until the earlier one's result is close enough.

Top module: `imul_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, grant_o, busy_o, e0_block_o and result_valid_o are 0, and result_size_o is 0.
- R2: Size code 0 (32-bit low), 1 (64-bit low) and 2 (64-bit high) have base latencies of 8, 12 and 14 cycles. result_valid_o goes high for exactly one cycle, at the grant cycle plus the latency plus any penalty. In that cycle result_size_o shows the multiply's size code.
- R3: grant_o is a one-cycle pulse. busy_o is high from the grant cycle for 4 cycles (code 0) or 8 cycles (codes 1 and 2). A request is granted in the first cycle after it is presented in which no rule below forbids it, so that back-to-back multiplies are 4 or 8 cycles apart.
- R4: e0_block_o is high in every grant cycle, and again 5, 9 or 11 cycles after a grant of code 0, 1 or 2.
- R5: No grant falls into a cycle that an earlier multiply has reserved on E0.
- R6: Take the effective distance to be req_dist_i plus the cycles already waited. A value of 1 adds 2 cycles of latency and a value of 2 adds 1. A value of 3 or more adds nothing, and so does req_dist_i equal to 0, which means no producer.
- R7: With req_dep_mul_i set, the grant comes no earlier than 9, 13 or 15 cycles after the previous grant, for a previous multiply of code 0, 1 or 2.
- R8: A grant is delayed when its completion cycle is already taken by an earlier multiply, so that result pulses never merge.
- R9: A request with size code 3 is never granted and leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Multiply request, held until granted |
| req_size_i | input | 2 | Size code: 0 32-bit low, 1 64-bit low, 2 64-bit high, 3 illegal |
| req_dist_i | input | DIST_W | Producer distance at first presentation, 0 for none |
| req_dep_mul_i | input | 1 | Operand comes from the last granted multiply |
| grant_o | output | 1 | Multiply issues in this cycle |
| busy_o | output | 1 | Multiplier occupied |
| e0_block_o | output | 1 | E0 is reserved in this cycle |
| result_valid_o | output | 1 | A multiply result is ready in this cycle |
| result_size_o | output | 2 | Size code of the completing multiply |

## Verification
The three legal sizes are first issued on their own with no dependency, which separates the three latency, occupancy and writeback-slot tables. Directed sequences then follow: a request that lands on a reserved writeback cycle, a request whose completion would coincide with an earlier one, dependent chains after each size, and producer distances of 1, 2 and 3, some of them aged by stalls. Each of these isolates one stall or penalty rule. A long run of random sizes, gaps, distances and dependency flags then mixes all the rules together. Grant timing is compared cycle by cycle, so a stall that comes one cycle too early or too late is caught, and the offending rule is named.

// File: rtl/imul_sched_pkg.sv
package imul_sched_pkg;

  typedef enum logic [1:0] {
    MSZ_L32 = 2'd0,
    MSZ_L64 = 2'd1,
    MSZ_H64 = 2'd2,
    MSZ_BAD = 2'd3
  } msz_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/imul_slot_ring.sv
// Cycle reservation ring: slot 0 is the current cycle, slot k is k cycles
// ahead. Set indices are relative to the next cycle.
module imul_slot_ring #(
  parameter int DEPTH = 18,
  parameter int IDX_W = 5,
  parameter int DAT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_a_en,
  input  logic [IDX_W-1:0] set_a_idx,
  input  logic             set_b_en,
  input  logic [IDX_W-1:0] set_b_idx,
  input  logic [DAT_W-1:0] set_dat,
  output logic [DEPTH-1:0] occ_o,
  output logic [DAT_W-1:0] head_dat_o
);

  logic             occ_q [DEPTH];
  logic [DAT_W-1:0] dat_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             nxt_occ;
    logic [DAT_W-1:0] nxt_dat;
    logic             hit_a;
    logic             hit_b;

    if (i == DEPTH - 1) begin : g_top
      assign nxt_occ = 1'b0;
      assign nxt_dat = '0;
    end else begin : g_mid
      assign nxt_occ = occ_q[i+1];
      assign nxt_dat = dat_q[i+1];
    end

    assign hit_a = set_a_en && (set_a_idx == IDX_W'(i));
    assign hit_b = set_b_en && (set_b_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        occ_q[i] <= 1'b0;
        dat_q[i] <= '0;
      end else begin
        occ_q[i] <= nxt_occ | hit_a | hit_b;
        dat_q[i] <= (hit_a || hit_b) ? set_dat : nxt_dat;
      end
    end

    assign occ_o[i] = occ_q[i];
  end

  assign head_dat_o = dat_q[0];

endmodule

// File: rtl/imul_fwd_penalty.sv
// Ages the producer distance while a request waits and turns the
// effective distance into extra latency cycles.
module imul_fwd_penalty #(
  parameter int DIST_W   = 4,
  parameter int WAIT_W   = 4,
  parameter int PEN_W    = 2,
  parameter int PEN_NEAR = 2,
  parameter int PEN_FAR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              accept_i,
  input  logic [DIST_W-1:0] dist_i,
  output logic [PEN_W-1:0]  pen_o
);

  localparam int EFF_W = ((DIST_W > WAIT_W) ? DIST_W : WAIT_W) + 1;

  logic [WAIT_W-1:0] wait_q;
  logic [EFF_W-1:0]  eff;

  always_ff @(posedge clk) begin
    if (rst || !req_valid_i || accept_i) begin
      wait_q <= '0;
    end else if (wait_q != {WAIT_W{1'b1}}) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assign eff = EFF_W'(dist_i) + EFF_W'(wait_q);

  always_comb begin
    if (dist_i == '0) begin
      pen_o = '0;
    end else if (eff == EFF_W'(1)) begin
      pen_o = PEN_W'(PEN_NEAR);
    end else if (eff == EFF_W'(2)) begin
      pen_o = PEN_W'(PEN_FAR);
    end else begin
      pen_o = '0;
    end
  end

endmodule

// File: rtl/imul_chain_guard.sv
// Holds back a multiply whose operand is the previous multiply's result
// until the required gap since that multiply's grant has elapsed.
module imul_chain_guard #(
  parameter int GAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             dep_i,
  output logic             ok_o
);

  logic             have_q;
  logic [GAP_W-1:0] age_q;
  logic [GAP_W-1:0] need_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
      age_q  <= '0;
      need_q <= '0;
    end else if (accept_i) begin
      have_q <= 1'b1;
      age_q  <= '0;
      need_q <= gap_i;
    end else if (age_q != {GAP_W{1'b1}}) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign ok_o = !dep_i || !have_q ||
                (({1'b0, age_q} + (GAP_W+1)'(1)) >= {1'b0, need_q});

endmodule

// File: rtl/imul_sched.sv
module imul_sched
  import imul_sched_pkg::*;
#(
  parameter int DIST_W   = 4,
  parameter int WAIT_W   = 4,
  parameter int LAT_L32  = 8,
  parameter int LAT_L64  = 12,
  parameter int LAT_H64  = 14,
  parameter int OCC_L32  = 4,
  parameter int OCC_W64  = 8,
  parameter int WB_L32   = 5,
  parameter int WB_L64   = 9,
  parameter int WB_H64   = 11,
  parameter int PEN_NEAR = 2,
  parameter int PEN_FAR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [1:0]        req_size_i,
  input  logic [DIST_W-1:0] req_dist_i,
  input  logic              req_dep_mul_i,
  output logic              grant_o,
  output logic              busy_o,
  output logic              e0_block_o,
  output logic              result_valid_o,
  output logic [1:0]        result_size_o
);

  localparam int MAX_LAT   = max3(LAT_L32, LAT_L64, LAT_H64);
  localparam int MAX_WB    = max3(WB_L32, WB_L64, WB_H64);
  localparam int MAX_PEN   = max3(PEN_NEAR, PEN_FAR, 0);
  localparam int RES_DEPTH = MAX_LAT + MAX_PEN + 2;
  localparam int E0_DEPTH  = MAX_WB + 2;
  localparam int RIDX_W    = $clog2(RES_DEPTH);
  localparam int EIDX_W    = $clog2(E0_DEPTH);
  localparam int CNT_W     = $clog2(max3(OCC_L32, OCC_W64, 1) + 1);
  localparam int PEN_W     = $clog2(MAX_PEN + 1);

  // Size decode
  logic              legal;
  logic [RIDX_W-1:0] lat;
  logic [CNT_W-1:0]  occ;
  logic [EIDX_W-1:0] wb;

  always_comb begin
    legal = 1'b1;
    lat   = '0;
    occ   = '0;
    wb    = '0;
    case (msz_e'(req_size_i))
      MSZ_L32: begin lat = RIDX_W'(LAT_L32); occ = CNT_W'(OCC_L32); wb = EIDX_W'(WB_L32); end
      MSZ_L64: begin lat = RIDX_W'(LAT_L64); occ = CNT_W'(OCC_W64); wb = EIDX_W'(WB_L64); end
      MSZ_H64: begin lat = RIDX_W'(LAT_H64); occ = CNT_W'(OCC_W64); wb = EIDX_W'(WB_H64); end
      default: legal = 1'b0;
    endcase
  end

  logic [PEN_W-1:0]     pen;
  logic                 chain_ok;
  logic                 accept;
  logic [RIDX_W-1:0]    res_idx;
  logic [RIDX_W-1:0]    res_chk;
  logic [EIDX_W-1:0]    e0_chk;
  logic [E0_DEPTH-1:0]  e0_occ;
  logic [RES_DEPTH-1:0] res_occ;
  logic [0:0]           e0_head;
  logic [1:0]           res_head;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     cnt_d;
  logic                 busy_ok;
  logic                 grant_q;
  logic                 busy_q;

  imul_fwd_penalty #(
    .DIST_W   (DIST_W),
    .WAIT_W   (WAIT_W),
    .PEN_W    (PEN_W),
    .PEN_NEAR (PEN_NEAR),
    .PEN_FAR  (PEN_FAR)
  ) pen_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .accept_i    (accept),
    .dist_i      (req_dist_i),
    .pen_o       (pen)
  );

  imul_chain_guard #(
    .GAP_W (RIDX_W)
  ) chain_i (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .gap_i    (lat + RIDX_W'(1)),
    .dep_i    (req_dep_mul_i),
    .ok_o     (chain_ok)
  );

  assign res_idx = lat + RIDX_W'(pen);
  assign res_chk = res_idx + RIDX_W'(1);
  assign e0_chk  = wb + EIDX_W'(1);
  assign busy_ok = (cnt_q <= CNT_W'(1));

  // Issue lands next cycle: check the rings one slot further ahead.
  assign accept = req_valid_i && legal && busy_ok && chain_ok &&
                  !e0_occ[1] && !e0_occ[e0_chk] && !res_occ[res_chk];

  imul_slot_ring #(
    .DEPTH (E0_DEPTH),
    .IDX_W (EIDX_W),
    .DAT_W (1)
  ) e0_ring_i (
    .clk        (clk),
    .rst        (rst),
    .set_a_en   (accept),
    .set_a_idx  ('0),
    .set_b_en   (accept),
    .set_b_idx  (wb),
    .set_dat    (1'b1),
    .occ_o      (e0_occ),
    .head_dat_o (e0_head)
  );

  imul_slot_ring #(
    .DEPTH (RES_DEPTH),
    .IDX_W (RIDX_W),
    .DAT_W (2)
  ) res_ring_i (
    .clk        (clk),
    .rst        (rst),
    .set_a_en   (accept),
    .set_a_idx  (res_idx),
    .set_b_en   (1'b0),
    .set_b_idx  ('0),
    .set_dat    (req_size_i),
    .occ_o      (res_occ),
    .head_dat_o (res_head)
  );

  always_comb begin
    if (accept) begin
      cnt_d = occ;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      busy_q  <= (cnt_d != '0);
      grant_q <= accept;
    end
  end

  assign grant_o        = grant_q;
  assign busy_o         = busy_q;
  assign e0_block_o     = e0_head[0];
  assign result_valid_o = res_occ[0];
  assign result_size_o  = res_head;

endmodule

// File: rtl/imul_sched_chk.sv
module imul_sched_chk #(
  parameter int DIST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [1:0]        req_size_i,
  input logic [DIST_W-1:0] req_dist_i,
  input logic              req_dep_mul_i,
  input logic              grant_o,
  input logic              busy_o,
  input logic              e0_block_o,
  input logic              result_valid_o,
  input logic [1:0]        result_size_o
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!grant_o && !busy_o && !e0_block_o && !result_valid_o)); // R1

  AST_RESULT_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> (result_size_o != 2'd3)); // R2

  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> !grant_o); // R3

  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> busy_o); // R3

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> busy_o); // R3

  AST_GRANT_TAKES_E0: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> e0_block_o); // R4

  AST_BAD_SIZE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_size_i == 2'd3) |=> !grant_o); // R9

endmodule

bind imul_sched imul_sched_chk #(.DIST_W(DIST_W)) chk_i (.*);

// File: tb/imul_sched_tb_top.sv
module imul_sched_tb_top;

  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [DW-1:0] req_dist = '0;
  logic          req_dep = 1'b0;
  logic          grant, busy, e0_block, res_valid;
  logic [1:0]    res_size;

  always #5 clk = ~clk;

  imul_sched dut_i (
    .clk            (clk),
    .rst            (rst),
    .req_valid_i    (req_valid),
    .req_size_i     (req_size),
    .req_dist_i     (req_dist),
    .req_dep_mul_i  (req_dep),
    .grant_o        (grant),
    .busy_o         (busy),
    .e0_block_o     (e0_block),
    .result_valid_o (res_valid),
    .result_size_o  (res_size)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Reference state, indexed by cycle modulo 64
  int    cyc = 0;
  bit    exp_e0  [64];
  bit    exp_res [64];
  int    exp_rsz [64];
  int    busy_end = 0;
  int    prev_g = 0;
  int    prev_sz = 0;
  bit    have_prev = 1'b0;
  int    wait_n = 0;
  bit    exp_grant = 1'b0;
  string why = "R3";

  function automatic int f_lat(int s);
    return (s == 0) ? 8 : (s == 1) ? 12 : 14;
  endfunction
  function automatic int f_occ(int s);
    return (s == 0) ? 4 : 8;
  endfunction
  function automatic int f_wb(int s);
    return (s == 0) ? 5 : (s == 1) ? 9 : 11;
  endfunction
  function automatic int f_pen(int d, int w);
    if (d == 0) return 0;
    if (d + w == 1) return 2;
    if (d + w == 2) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // Model the edge closing the current cycle, then move to the next
  // negedge and compare all outputs for that cycle.
  task automatic advance();
    int  n;
    int  s;
    int  p;
    bit  acc;
    n   = cyc + 1;
    acc = 1'b0;
    why = "R3";
    if (req_valid) begin
      s = int'(req_size);
      p = f_pen(int'(req_dist), wait_n);
      if (s == 3) why = "R9";
      else if (n < busy_end) why = "R3";
      else if (req_dep && have_prev && (n - prev_g) < f_lat(prev_sz) + 1) why = "R7";
      else if (exp_e0[n % 64] || exp_e0[(n + f_wb(s)) % 64]) why = "R5";
      else if (exp_res[(n + f_lat(s) + p) % 64]) why = "R8";
      else acc = 1'b1;
      if (acc) begin
        exp_e0[n % 64] = 1'b1;
        exp_e0[(n + f_wb(s)) % 64] = 1'b1;
        exp_res[(n + f_lat(s) + p) % 64] = 1'b1;
        exp_rsz[(n + f_lat(s) + p) % 64] = s;
        busy_end  = n + f_occ(s);
        prev_g    = n;
        prev_sz   = s;
        have_prev = 1'b1;
        wait_n    = 0;
      end else begin
        wait_n++;
      end
    end else begin
      wait_n = 0;
    end
    exp_grant = acc;
    @(negedge clk);
    cyc++;
    chk(grant == exp_grant, why, "grant_o", int'(grant), int'(exp_grant));
    chk(busy == (cyc < busy_end), "R3", "busy_o", int'(busy), int'(cyc < busy_end));
    chk(e0_block == exp_e0[cyc % 64], "R4", "e0_block_o", int'(e0_block), int'(exp_e0[cyc % 64]));
    chk(res_valid == exp_res[cyc % 64], "R2/R6", "result_valid_o", int'(res_valid), int'(exp_res[cyc % 64]));
    if (res_valid && exp_res[cyc % 64])
      chk(int'(res_size) == exp_rsz[cyc % 64], "R2", "result_size_o", int'(res_size), exp_rsz[cyc % 64]);
    exp_e0[cyc % 64]  = 1'b0;
    exp_res[cyc % 64] = 1'b0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) advance();
  endtask

  task automatic issue(int s, int d, bit dep, int maxw);
    req_valid = 1'b1;
    req_size  = 2'(s);
    req_dist  = DW'(d);
    req_dep   = dep;
    for (int i = 0; i < maxw; i++) begin
      advance();
      if (grant) break;
    end
    req_valid = 1'b0;
    req_size  = 2'd0;
    req_dist  = '0;
    req_dep   = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      exp_e0[i] = 1'b0; exp_res[i] = 1'b0; exp_rsz[i] = 0;
    end
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!grant, "R1", "grant_o in reset", int'(grant), 0);
    chk(!busy, "R1", "busy_o in reset", int'(busy), 0);
    chk(!e0_block, "R1", "e0_block_o in reset", int'(e0_block), 0);
    chk(!res_valid && res_size == 2'd0, "R1", "result in reset", int'(res_valid), 0);
    rst = 1'b0;
    cyc = 0;

    // R2: each size alone
    for (int s = 0; s < 3; s++) begin
      issue(s, 0, 1'b0, 30);
      idle(20);
    end
    // R3: back-to-back spacing
    issue(0, 0, 1'b0, 30); issue(0, 0, 1'b0, 30); issue(1, 0, 1'b0, 30); issue(2, 0, 1'b0, 30);
    idle(20);
    // R5: request landing on the writeback slot of a 32-bit multiply
    issue(0, 0, 1'b0, 30); idle(4); issue(0, 0, 1'b0, 30);
    idle(20);
    issue(1, 0, 1'b0, 30); idle(8); issue(0, 0, 1'b0, 30);
    idle(20);
    // R6: distances 1, 2, 3 without waiting, then distance 1 aged by a stall
    issue(0, 1, 1'b0, 30); idle(20);
    issue(0, 2, 1'b0, 30); idle(20);
    issue(0, 3, 1'b0, 30); idle(20);
    issue(1, 0, 1'b0, 30); idle(5); issue(0, 1, 1'b0, 30); idle(20);
    // R7: dependent chains after each size
    issue(2, 0, 1'b0, 30); issue(0, 0, 1'b1, 30); issue(0, 0, 1'b1, 30);
    issue(1, 0, 1'b0, 30); issue(1, 0, 1'b1, 30);
    idle(20);
    // R8: completion collision 64-bit high +2 against 32-bit
    issue(2, 1, 1'b0, 30); issue(0, 0, 1'b0, 30);
    idle(20);
    // R9: illegal size held, then dropped
    issue(3, 0, 1'b0, 6);
    idle(3);

    // Random mix
    for (int k = 0; k < 2500; k++) begin
      int s;
      idle(int'($urandom_range(0, 3)));
      s = ($urandom_range(0, 19) == 0) ? 3 : int'($urandom_range(0, 2));
      issue(s, int'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), (s == 3) ? 4 : 40);
    end
    idle(25);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule